// File: doc/BRIEF.md
# Multi-source XOR descriptor executor

This block runs one descriptor at a time against a word-addressed scratch memory inside the block. A descriptor is a 1024-bit vector of thirty-two 32-bit words, and it is captured in one cycle. A control word selects one of three operations:

- no-op;
- copy of one buffer;
- XOR of up to eight source buffers into one destination buffer.

The engine makes one memory read per clock. It builds each destination word by combining the same word offset from every active source. It writes that word on the cycle it reads the last source.

When the descriptor finishes, a one-cycle completion pulse carries three things: the descriptor's 16-bit identifier, a status field and the interrupt request the descriptor asked for. Descriptors that cannot be executed are rejected without touching memory. A host port loads the scratch memory and reads it back.

Top module: `xde_exec`

## Requirements
- R1: After reset `busy` and `done` are low.
- R2: A descriptor presented on `desc_valid` while `busy` is low is captured, and `busy` is high from the next cycle. A descriptor presented while `busy` is high is ignored: it produces no completion and no memory write.
- R3: The operation comes from control word (descriptor word 2) bits [31:28]. Code 0 is no-op, 1 is copy and 6 is XOR. Any other code completes with status bit 0 set and writes nothing.
- R4: Copy takes its source byte address from word 4 (low 32 bits) and word 5 (bits [15:0] high), and its destination from words 6 and 7. It ignores the source-count field and moves the given number of bytes word by word.
- R5: XOR takes its destination from words 6 and 7. Sources are packed in groups starting at word 8, three words per pair of sources:
  - first the low address of the even source;
  - then the low address of the odd source;
  - then a word with the odd source's high half in [31:16] and the even source's high half in [15:0].

  Each destination word is the XOR of the same word offset in every active source.
- R6: Control bits [25:22] give the XOR source count. A count of 0 or above 8 completes with status bit 0 set and writes nothing.
- R7: XOR requires the parity-output enable, control bit 17. If that bit is clear, the descriptor completes with status bit 0 set and writes nothing.
- R8: Word 3 holds the byte count.
  - A count of zero completes with status 0 and writes nothing.
  - A count that is not a multiple of 4 completes with status bit 0 set and writes nothing.
- R9: A no-op completes with status 0, writes nothing, and still reports the interrupt request.
- R10: On completion `done` is high for exactly one cycle, and `busy` is low in that same cycle. Alongside it:
  - `done_id` is word 0 bits [15:0];
  - `done_irq` is control bit 27;
  - `done_flags` bit 0 flags a rejected descriptor, and the other bits are zero.
- R11: Counted from the clock edge that captures the descriptor, `done` is high after edge 1+S*W, where S is the number of sources (1 for copy) and W is the byte count divided by 4. Rejected, no-op and zero-length descriptors finish after edge 1.
- R12: A byte address selects scratch word (address / 4) modulo DEPTH. The host port writes on the clock edge when `mem_wr_en` is high. The host read port returns the addressed word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor present on `desc_in` |
| desc_in | input | 1024 | Descriptor, word i at bits [32*i+31:32*i] |
| busy | output | 1 | A descriptor is being executed |
| done | output | 1 | One-cycle completion pulse |
| done_id | output | 16 | Identifier of the completed descriptor |
| done_flags | output | 16 | Status, bit 0 = rejected |
| done_irq | output | 1 | Interrupt requested by the completed descriptor |
| mem_wr_en | input | 1 | Host write enable to scratch memory |
| mem_wr_addr | input | 8 | Host write word index |
| mem_wr_data | input | 32 | Host write data |
| mem_rd_addr | input | 8 | Host read word index |
| mem_rd_data | output | 32 | Host read data |

## Verification
The checker assumes three things about the inputs:
- `rst_n` is held low for at least one clock edge before any descriptor arrives;
- `desc_in` is stable during the cycle that `desc_valid` is high;
- the host port writes no scratch word while the engine is busy.

The bench drives every input at the falling edge. It loads and reads scratch memory only while `busy` is low. It presents a descriptor during a busy period only in the scenario that checks that descriptor is ignored.

// File: rtl/xde_pkg.sv
package xde_pkg;

   // Descriptor word positions
   localparam int W_HDR   = 0;
   localparam int W_CTL   = 2;
   localparam int W_LEN   = 3;
   localparam int W_CSRC  = 4;
   localparam int W_DST   = 6;
   localparam int W_XSRC  = 8;

   // Control word fields
   localparam int CTL_OP_LSB  = 28;
   localparam int CTL_IRQ_BIT = 27;
   localparam int CTL_CNT_LSB = 22;
   localparam int CTL_PEN_BIT = 17;

   localparam logic [3:0] OP_NOP  = 4'd0;
   localparam logic [3:0] OP_COPY = 4'd1;
   localparam logic [3:0] OP_XOR  = 4'd6;

   localparam int FLAG_ERR = 0;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_RUN   = 2'd2
   } xde_state_e;

   function automatic int unsigned sel_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/xde_decode.sv
module xde_decode
   import xde_pkg::*;
#(
   parameter int DESC_WORDS = 32,
   parameter int MAX_SRC    = 8,
   parameter int IDX_W      = 8
)(
   input  logic [32*DESC_WORDS-1:0]          desc_i,
   output logic [15:0]                       id_o,
   output logic                              irq_o,
   output logic                              err_o,
   output logic                              skip_o,
   output logic [3:0]                        cnt_o,
   output logic [29:0]                       nwords_o,
   output logic [IDX_W-1:0]                  dst_o,
   output logic [MAX_SRC-1:0][IDX_W-1:0]     src_o
);

   logic [31:0] ctl_w;
   logic [31:0] len_w;
   logic [3:0]  op;
   logic [3:0]  cnt_field;
   logic        p_en;
   logic        is_nop;
   logic        is_copy;
   logic        is_xor;
   logic        bad_op;
   logic        bad_cnt;
   logic        bad_len;
   logic [MAX_SRC-1:0][IDX_W-1:0] xsrc;
   logic [IDX_W-1:0] csrc;
   logic        unused_desc_bits;

   assign ctl_w     = desc_i[32*W_CTL +: 32];
   assign len_w     = desc_i[32*W_LEN +: 32];
   assign op        = ctl_w[CTL_OP_LSB +: 4];
   assign cnt_field = ctl_w[CTL_CNT_LSB +: 4];
   assign p_en      = ctl_w[CTL_PEN_BIT];

   assign is_nop  = (op == OP_NOP);
   assign is_copy = (op == OP_COPY);
   assign is_xor  = (op == OP_XOR);

   assign bad_op  = !(is_nop || is_copy || is_xor);
   assign bad_cnt = is_xor && ((cnt_field == 4'd0) ||
                               (cnt_field > 4'(MAX_SRC)) || !p_en);
   assign bad_len = (is_copy || is_xor) && (len_w[1:0] != 2'b00);

   assign id_o     = desc_i[32*W_HDR +: 16];
   assign irq_o    = ctl_w[CTL_IRQ_BIT];
   assign err_o    = bad_op || bad_cnt || bad_len;
   assign nwords_o = len_w[31:2];
   assign skip_o   = is_nop || (nwords_o == 30'd0);
   assign cnt_o    = is_copy ? 4'd1 : cnt_field;
   assign dst_o    = desc_i[32*W_DST + 2 +: IDX_W];
   assign csrc     = desc_i[32*W_CSRC + 2 +: IDX_W];

   // Source slots: pairs of sources share three words, the even one first.
   // Only the low address word reaches the index; the high halves sit
   // above the scratch range.
   for (genvar k = 0; k < MAX_SRC; k++) begin : g_slot
      localparam int PAIR_BASE = W_XSRC + 3 * (k / 2);
      localparam int LOW_WORD  = PAIR_BASE + (k % 2);
      assign xsrc[k] = desc_i[32*LOW_WORD + 2 +: IDX_W];
      if (k == 0) begin : g_first
         assign src_o[k] = is_copy ? csrc : xsrc[k];
      end else begin : g_rest
         assign src_o[k] = xsrc[k];
      end
   end

   assign unused_desc_bits = ^desc_i;

endmodule

// File: rtl/xde_scratch.sv
module xde_scratch #(
   parameter int DEPTH = 256,
   parameter int IDX_W = 8
)(
   input  logic              clk,
   input  logic [IDX_W-1:0]  eng_ra,
   output logic [31:0]       eng_rd,
   input  logic              eng_we,
   input  logic [IDX_W-1:0]  eng_wa,
   input  logic [31:0]       eng_wd,
   input  logic              host_we,
   input  logic [IDX_W-1:0]  host_wa,
   input  logic [31:0]       host_wd,
   input  logic [IDX_W-1:0]  host_ra,
   output logic [31:0]       host_rd
);

   logic [31:0] mem [DEPTH];

   assign eng_rd  = mem[eng_ra];
   assign host_rd = mem[host_ra];

   // The engine wins a same-cycle collision.
   always_ff @(posedge clk) begin
      if (eng_we) begin
         mem[eng_wa] <= eng_wd;
      end else if (host_we) begin
         mem[host_wa] <= host_wd;
      end
   end

endmodule

// File: rtl/xde_seq.sv
module xde_seq
   import xde_pkg::*;
#(
   parameter int MAX_SRC = 8,
   parameter int IDX_W   = 8
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          desc_valid_i,
   output logic                          accept_o,
   output logic                          busy_o,
   input  logic                          err_i,
   input  logic                          skip_i,
   input  logic [3:0]                    cnt_i,
   input  logic [29:0]                   nwords_i,
   input  logic [IDX_W-1:0]              dst_i,
   input  logic [MAX_SRC-1:0][IDX_W-1:0] src_i,
   input  logic [15:0]                   id_i,
   input  logic                          irq_i,
   output logic [IDX_W-1:0]              rd_addr_o,
   input  logic [31:0]                   rd_data_i,
   output logic                          we_o,
   output logic [IDX_W-1:0]              wa_o,
   output logic [31:0]                   wd_o,
   output logic                          done_o,
   output logic [15:0]                   done_id_o,
   output logic [15:0]                   done_flags_o,
   output logic                          done_irq_o
);

   localparam int SEL_W = sel_width(MAX_SRC);

   xde_state_e       st;
   logic [29:0]      word_q;
   logic [SEL_W-1:0] sel_q;
   logic [31:0]      acc_q;
   logic [31:0]      acc_nxt;
   logic             last_src;
   logic             last_word;
   logic [IDX_W-1:0] woff;

   assign accept_o  = (st == ST_IDLE) && desc_valid_i;
   assign busy_o    = (st != ST_IDLE);
   assign woff      = word_q[IDX_W-1:0];
   assign rd_addr_o = src_i[sel_q] + woff;
   assign acc_nxt   = acc_q ^ rd_data_i;
   assign last_src  = (4'(sel_q) == (cnt_i - 4'd1));
   assign last_word = (word_q == (nwords_i - 30'd1));

   assign we_o = (st == ST_RUN) && last_src;
   assign wa_o = dst_i + woff;
   assign wd_o = acc_nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         word_q       <= '0;
         sel_q        <= '0;
         acc_q        <= '0;
         done_o       <= 1'b0;
         done_id_o    <= '0;
         done_flags_o <= '0;
         done_irq_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (desc_valid_i) begin
                  st <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               word_q <= '0;
               sel_q  <= '0;
               acc_q  <= '0;
               if (err_i || skip_i) begin
                  st                     <= ST_IDLE;
                  done_o                 <= 1'b1;
                  done_id_o              <= id_i;
                  done_irq_o             <= irq_i;
                  done_flags_o           <= '0;
                  done_flags_o[FLAG_ERR] <= err_i;
               end else begin
                  st <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (last_src) begin
                  acc_q <= '0;
                  sel_q <= '0;
                  if (last_word) begin
                     st           <= ST_IDLE;
                     done_o       <= 1'b1;
                     done_id_o    <= id_i;
                     done_irq_o   <= irq_i;
                     done_flags_o <= '0;
                  end else begin
                     word_q <= word_q + 30'd1;
                  end
               end else begin
                  acc_q <= acc_nxt;
                  sel_q <= sel_q + SEL_W'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/xde_exec.sv
module xde_exec
   import xde_pkg::*;
#(
   parameter int DESC_WORDS = 32,
   parameter int MAX_SRC    = 8,
   parameter int DEPTH      = 256,
   parameter int IDX_W      = $clog2(DEPTH)
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    desc_valid,
   input  logic [32*DESC_WORDS-1:0] desc_in,
   output logic                    busy,
   output logic                    done,
   output logic [15:0]             done_id,
   output logic [15:0]             done_flags,
   output logic                    done_irq,
   input  logic                    mem_wr_en,
   input  logic [IDX_W-1:0]        mem_wr_addr,
   input  logic [31:0]             mem_wr_data,
   input  logic [IDX_W-1:0]        mem_rd_addr,
   output logic [31:0]             mem_rd_data
);

   localparam int DESC_W    = 32 * DESC_WORDS;
   localparam int LAST_WORD = W_XSRC + 3 * ((MAX_SRC + 1) / 2) - 1;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_chk_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (IDX_W != $clog2(DEPTH) || IDX_W > 30) begin : g_chk_idx
      $error("IDX_W must equal log2(DEPTH) and fit the word counter");
   end
   if (MAX_SRC < 1 || MAX_SRC > 8) begin : g_chk_src
      $error("MAX_SRC must lie in 1..8");
   end
   if (LAST_WORD >= DESC_WORDS) begin : g_chk_layout
      $error("source slots do not fit in the descriptor");
   end

   logic [DESC_W-1:0]            desc_q;
   logic                         accept;
   logic [15:0]                  dec_id;
   logic                         dec_irq;
   logic                         dec_err;
   logic                         dec_skip;
   logic [3:0]                   dec_cnt;
   logic [29:0]                  dec_nwords;
   logic [IDX_W-1:0]             dec_dst;
   logic [MAX_SRC-1:0][IDX_W-1:0] dec_src;
   logic [IDX_W-1:0]             eng_ra;
   logic [31:0]                  eng_rd;
   logic                         eng_we;
   logic [IDX_W-1:0]             eng_wa;
   logic [31:0]                  eng_wd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         desc_q <= '0;
      end else if (accept) begin
         desc_q <= desc_in;
      end
   end

   xde_decode #(
      .DESC_WORDS (DESC_WORDS),
      .MAX_SRC    (MAX_SRC),
      .IDX_W      (IDX_W)
   ) i_decode (
      .desc_i   (desc_q),
      .id_o     (dec_id),
      .irq_o    (dec_irq),
      .err_o    (dec_err),
      .skip_o   (dec_skip),
      .cnt_o    (dec_cnt),
      .nwords_o (dec_nwords),
      .dst_o    (dec_dst),
      .src_o    (dec_src)
   );

   xde_seq #(
      .MAX_SRC (MAX_SRC),
      .IDX_W   (IDX_W)
   ) i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .desc_valid_i (desc_valid),
      .accept_o     (accept),
      .busy_o       (busy),
      .err_i        (dec_err),
      .skip_i       (dec_skip),
      .cnt_i        (dec_cnt),
      .nwords_i     (dec_nwords),
      .dst_i        (dec_dst),
      .src_i        (dec_src),
      .id_i         (dec_id),
      .irq_i        (dec_irq),
      .rd_addr_o    (eng_ra),
      .rd_data_i    (eng_rd),
      .we_o         (eng_we),
      .wa_o         (eng_wa),
      .wd_o         (eng_wd),
      .done_o       (done),
      .done_id_o    (done_id),
      .done_flags_o (done_flags),
      .done_irq_o   (done_irq)
   );

   xde_scratch #(
      .DEPTH (DEPTH),
      .IDX_W (IDX_W)
   ) i_scratch (
      .clk     (clk),
      .eng_ra  (eng_ra),
      .eng_rd  (eng_rd),
      .eng_we  (eng_we),
      .eng_wa  (eng_wa),
      .eng_wd  (eng_wd),
      .host_we (mem_wr_en),
      .host_wa (mem_wr_addr),
      .host_wd (mem_wr_data),
      .host_ra (mem_rd_addr),
      .host_rd (mem_rd_data)
   );

endmodule

// File: rtl/xde_checker.sv
module xde_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        desc_valid,
   input logic        busy,
   input logic        done,
   input logic        eng_we,
   input logic [15:0] done_flags
);

   a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && !busy |=> busy);

   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r11_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r3_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      eng_we |-> busy);

   a_r6_reject_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      done && done_flags[0] |-> !$past(eng_we));

endmodule

bind xde_exec xde_checker i_xde_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .desc_valid (desc_valid),
   .busy       (busy),
   .done       (done),
   .eng_we     (eng_we),
   .done_flags (done_flags)
);

// File: tb/test_xde_exec.sv
module test_xde_exec;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          desc_valid = 1'b0;
   logic [1023:0] desc_in = '0;
   logic          busy, done, done_irq;
   logic [15:0]   done_id, done_flags;
   logic          mem_wr_en = 1'b0;
   logic [7:0]    mem_wr_addr = '0;
   logic [31:0]   mem_wr_data = '0;
   logic [7:0]    mem_rd_addr = '0;
   logic [31:0]   mem_rd_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [31:0] d [32];
   logic [15:0] r_id, r_flags;
   logic        r_irq;

   always #4 clk = ~clk;

   xde_exec i_xde_exec (
      .clk, .rst_n, .desc_valid, .desc_in, .busy, .done, .done_id,
      .done_flags, .done_irq, .mem_wr_en, .mem_wr_addr, .mem_wr_data,
      .mem_rd_addr, .mem_rd_data
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog actual %0d expected below 100000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic clear_desc();
      for (int i = 0; i < 32; i++) d[i] = '0;
   endtask

   // ctrl: op [31:28], irq 27, count [25:22], parity enable 17
   task automatic set_ctl(input logic [3:0] op, input logic [3:0] cnt,
                          input logic pen, input logic irq);
      d[2] = '0;
      d[2][31:28] = op;
      d[2][27]    = irq;
      d[2][25:22] = cnt;
      d[2][17]    = pen;
   endtask

   task automatic set_src(input int k, input logic [31:0] lo, input logic [15:0] hi);
      int base;
      base = 8 + 3 * (k / 2);
      if (k % 2 == 0) begin
         d[base] = lo;
         d[base+2][15:0] = hi;
      end else begin
         d[base+1] = lo;
         d[base+2][31:16] = hi;
      end
   endtask

   function automatic logic [1023:0] pack();
      logic [1023:0] v;
      for (int i = 0; i < 32; i++) v[32*i +: 32] = d[i];
      return v;
   endfunction

   task automatic mem_put(input int idx, input logic [31:0] val);
      @(negedge clk);
      mem_wr_en = 1'b1;
      mem_wr_addr = 8'(idx);
      mem_wr_data = val;
      @(negedge clk);
      mem_wr_en = 1'b0;
   endtask

   task automatic mem_get(input int idx, output logic [31:0] val);
      @(negedge clk);
      mem_rd_addr = 8'(idx);
      #1 val = mem_rd_data;
   endtask

   task automatic run_desc(output int lat);
      @(negedge clk);
      desc_in = pack();
      desc_valid = 1'b1;
      @(negedge clk);
      desc_valid = 1'b0;
      lat = 0;
      while (lat < 400) begin
         @(negedge clk);
         lat++;
         if (done) break;
      end
      r_id = done_id;
      r_flags = done_flags;
      r_irq = done_irq;
   endtask

   function automatic logic [31:0] pat(input int k, input int w);
      return 32'h5A3C0000 ^ (k * 32'h01110011) ^ (w * 32'h10203041);
   endfunction

   task automatic t_reset();
      check("R1 busy after reset", 32'(busy), 0);
      check("R1 done after reset", 32'(done), 0);
   endtask

   task automatic t_copy();
      int lat;
      logic [31:0] v;
      for (int w = 0; w < 4; w++) mem_put(64 + w, pat(0, w));
      clear_desc();
      d[0] = 32'hBEEF_1234;
      set_ctl(4'd1, 4'd0, 1'b0, 1'b0);
      d[3] = 32'd16;
      d[4] = 32'h0000_0100; d[5] = 32'h0000_0007;
      d[6] = 32'h0000_1200; d[7] = 32'h0000_0003;   // R12: 0x1200/4 mod 256 = 128
      run_desc(lat);
      check("R11 copy latency", 32'(lat), 5);
      check("R10 copy id", 32'(r_id), 32'h1234);
      check("R10 copy flags", 32'(r_flags), 0);
      check("R10 copy irq", 32'(r_irq), 0);
      for (int w = 0; w < 4; w++) begin
         mem_get(128 + w, v);
         check("R4 R12 copy data", v, pat(0, w));
      end
      check("R10 busy low after done", 32'(busy), 0);
   endtask

   task automatic t_xor3();
      int lat;
      logic [31:0] v, e;
      for (int k = 0; k < 3; k++)
         for (int w = 0; w < 2; w++) mem_put(4 * (k + 1) + w, pat(k + 1, w));
      clear_desc();
      d[0] = 32'h0000_00A3;
      set_ctl(4'd6, 4'd3, 1'b1, 1'b1);
      d[3] = 32'd8;
      d[6] = 32'h0000_0380;
      for (int k = 0; k < 3; k++) set_src(k, 32'(16 * (k + 1)), 16'hF00 + 16'(k));
      run_desc(lat);
      check("R11 xor3 latency", 32'(lat), 7);
      check("R10 xor3 id", 32'(r_id), 32'h00A3);
      check("R10 xor3 irq", 32'(r_irq), 1);
      check("R5 xor3 flags", 32'(r_flags), 0);
      for (int w = 0; w < 2; w++) begin
         e = pat(1, w) ^ pat(2, w) ^ pat(3, w);
         mem_get(224 + w, v);
         check("R5 xor3 data", v, e);
      end
   endtask

   task automatic t_xor8();
      int lat;
      logic [31:0] v, e;
      e = '0;
      for (int k = 0; k < 8; k++) begin
         mem_put(16 + 4 * k, pat(10 + k, 0));
         e = e ^ pat(10 + k, 0);
      end
      clear_desc();
      d[0] = 32'h0000_0808;
      set_ctl(4'd6, 4'd8, 1'b1, 1'b0);
      d[3] = 32'd4;
      d[6] = 32'h0000_0300;
      for (int k = 0; k < 8; k++) set_src(k, 32'h40 + 32'(16 * k), 16'h1111 * 16'(k + 1));
      run_desc(lat);
      check("R11 xor8 latency", 32'(lat), 9);
      check("R6 xor8 flags", 32'(r_flags), 0);
      mem_get(192, v);
      check("R5 R6 xor8 data", v, e);
   endtask

   task automatic t_reject(input string req, input logic [3:0] op, input logic [3:0] cnt,
                           input logic pen, input logic [31:0] len);
      int lat;
      logic [31:0] v;
      mem_put(240, 32'hDEAD_0F0F);
      clear_desc();
      d[0] = 32'h0000_0E0E;
      set_ctl(op, cnt, pen, 1'b0);
      d[3] = len;
      d[4] = 32'h40;
      d[6] = 32'h3C0;
      set_src(0, 32'h40, 16'h0);
      run_desc(lat);
      check({req, " reject latency"}, 32'(lat), 1);
      check({req, " reject flag"}, 32'(r_flags), 1);
      mem_get(240, v);
      check({req, " reject no write"}, v, 32'hDEAD_0F0F);
   endtask

   task automatic t_zero_len();
      int lat;
      logic [31:0] v;
      mem_put(240, 32'h1357_9BDF);
      clear_desc();
      set_ctl(4'd1, 4'd0, 1'b0, 1'b0);
      d[3] = 32'd0;
      d[4] = 32'h40;
      d[6] = 32'h3C0;
      run_desc(lat);
      check("R8 zero length latency", 32'(lat), 1);
      check("R8 zero length flags", 32'(r_flags), 0);
      mem_get(240, v);
      check("R8 zero length no write", v, 32'h1357_9BDF);
   endtask

   task automatic t_noop();
      int lat;
      clear_desc();
      d[0] = 32'hFFFF_0C0D;
      set_ctl(4'd0, 4'd0, 1'b0, 1'b1);
      d[3] = 32'd64;
      run_desc(lat);
      check("R9 noop latency", 32'(lat), 1);
      check("R9 noop flags", 32'(r_flags), 0);
      check("R9 noop irq", 32'(r_irq), 1);
      check("R9 noop id", 32'(r_id), 32'h0C0D);
   endtask

   task automatic t_busy_ignore();
      int lat;
      int extra;
      logic [31:0] v;
      for (int w = 0; w < 4; w++) mem_put(64 + w, pat(20, w));
      mem_put(176, 32'hCAFE_0001);
      clear_desc();
      d[0] = 32'h0000_0001;
      set_ctl(4'd1, 4'd0, 1'b0, 1'b0);
      d[3] = 32'd16;
      d[4] = 32'h100;
      d[6] = 32'h200;
      @(negedge clk);
      desc_in = pack();
      desc_valid = 1'b1;
      @(negedge clk);
      check("R2 busy after accept", 32'(busy), 1);
      d[0] = 32'h0000_0002;
      d[3] = 32'd4;
      d[6] = 32'h2C0;
      desc_in = pack();
      @(negedge clk);
      @(negedge clk);
      desc_valid = 1'b0;
      lat = 2;
      while (lat < 400 && !done) begin
         @(negedge clk);
         lat++;
      end
      check("R2 R11 first completes", 32'(lat), 5);
      check("R2 first id", 32'(done_id), 1);
      extra = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (done || busy) extra++;
      end
      check("R2 ignored descriptor no completion", 32'(extra), 0);
      mem_get(176, v);
      check("R2 ignored descriptor no write", v, 32'hCAFE_0001);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_copy();
      t_xor3();
      t_xor8();
      t_reject("R3 op5", 4'd5, 4'd1, 1'b1, 32'd4);
      t_reject("R6 count0", 4'd6, 4'd0, 1'b1, 32'd4);
      t_reject("R6 count9", 4'd6, 4'd9, 1'b1, 32'd4);
      t_reject("R7 no parity", 4'd6, 4'd1, 1'b0, 32'd4);
      t_reject("R8 odd length", 4'd1, 4'd0, 1'b0, 32'd6);
      t_zero_len();
      t_noop();
      t_busy_ignore();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule